// File: doc/BRIEF.md
# Input Level-Change Detector

This block watches a small group of general-purpose input pins and reports when one of them has settled at a new level. Each pin is first brought into the system clock domain. It is then examined only on a slow sample tick that the surrounding logic derives from the baud divider, about 38.4 kHz, or one sample roughly every 26 microseconds. A new level is accepted only when two tick samples in a row agree on it. Short glitches are therefore thrown away. A change that lasts two sample periods is always caught.

Each accepted transition, rising or falling, sets a sticky change flag for that pin. The flag stays set until the host reads the change register, which is signalled by a one-cycle read strobe. The read word carries the accepted pin levels in its low half and the change flags in its high half. An interrupt request is raised while any flag is set and the interrupt enable is high.

Top module: `ipchg_detect`

## Requirements
- R1: After reset, every accepted level reads 1 (idle high), every change flag reads 0 and `irq_o` is low.
- R2: An accepted level is updated only at the clock edge that ends a cycle with `smp_tick_i` high. It takes a new value only when that tick's synchronised sample and the previous tick's sample both show the new value. This holds for both rising and falling changes.
- R3: A pin level that shows up at only one tick and is gone by the next one does not change the accepted level and does not set a change flag.
- R4: When an accepted level changes, the change flag for that pin is 1 at the same clock edge. Each pin sets only its own flag.
- R5: A change flag that is 1 stays 1 until a clock edge that ends a cycle with `rd_strobe_i` high. That edge clears all flags.
- R6: If a change is accepted at the same edge that a read clears the flags, the flag for that change stays set. Every other flag is cleared.
- R7: `irq_o` is high exactly when `irq_en_i` is high and at least one change flag is 1. It follows `irq_en_i` in the same cycle.
- R8: `rd_data_o[NUM_IN-1:0]` equals the accepted levels, with bit i for pin i. `rd_data_o[2*NUM_IN-1:NUM_IN]` equals the change flags, with bit NUM_IN+i for pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NUM_IN | Raw input pins, asynchronous to clk |
| smp_tick_i | input | 1 | One-cycle sample-enable pulse at the slow sample rate |
| rd_strobe_i | input | 1 | One-cycle pulse when the host reads the change register |
| irq_en_i | input | 1 | Interrupt enable |
| level_o | output | NUM_IN | Accepted (filtered) pin levels |
| delta_o | output | NUM_IN | Sticky change flags |
| rd_data_o | output | 2*NUM_IN | Read word: {change flags, accepted levels} |
| irq_o | output | 1 | Interrupt request |

## Verification
If the stored previous sample for a pin is wrong, the accepted level moves one tick early or one tick late. That shows on `level_o` and `delta_o` at the edge right after the affected tick. A flag register that clears without a read, or misses a change that coincides with a read, shows on `delta_o` and `irq_o` at the very next edge. A wrong synchroniser depth moves every acceptance by whole cycles. That can only be seen when a pin changes close to a tick, so the bench changes the pins at random offsets from the ticks.

// File: rtl/ipchg_pkg.sv
package ipchg_pkg;
  // Pins are pulled up, so the idle level is high.
  localparam logic IDLE_LVL = 1'b1;

  // Per-pin filter state: accepted level and sample seen at the previous tick.
  typedef struct packed {
    logic level;
    logic prev;
  } flt_state_t;
endpackage

// File: rtl/ipchg_sync.sv
module ipchg_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_V  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb begin
    chain_d[0] = din;
    for (int i = 1; i < STAGES; i++) chain_d[i] = chain_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {(STAGES*W){RST_V}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ipchg_filter.sv
module ipchg_filter
  import ipchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic smp,
  output logic level,
  output logic chg
);
  flt_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    chg  = 1'b0;
    if (tick) begin
      st_d.prev = smp;
      if ((smp == st_q.prev) && (smp != st_q.level)) begin
        st_d.level = smp;
        chg        = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= '{level: IDLE_LVL, prev: IDLE_LVL};
    else if (tick) st_q <= st_d;
  end

  assign level = st_q.level;
endmodule

// File: rtl/ipchg_flags.sv
module ipchg_flags #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] chg,
  input  logic         rd,
  input  logic         en,
  output logic [W-1:0] flags,
  output logic         irq
);
  logic [W-1:0] flags_d;
  logic         upd;

  always_comb begin
    flags_d = (flags & ~{W{rd}}) | chg;
    upd     = rd | (|chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= flags_d;
  end

  assign irq = en & (|flags);
endmodule

// File: rtl/ipchg_detect.sv
module ipchg_detect
  import ipchg_pkg::*;
#(
  parameter int unsigned NUM_IN      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_IN-1:0]     pin_i,
  input  logic                  smp_tick_i,
  input  logic                  rd_strobe_i,
  input  logic                  irq_en_i,
  output logic [NUM_IN-1:0]     level_o,
  output logic [NUM_IN-1:0]     delta_o,
  output logic [2*NUM_IN-1:0]   rd_data_o,
  output logic                  irq_o
);
  localparam int unsigned RW = 2 * NUM_IN;

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic [NUM_IN-1:0] smp;
  logic [NUM_IN-1:0] chg;

  // Reset asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ipchg_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES), .RST_V(IDLE_LVL)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .din(pin_i), .dout(smp)
  );

  for (genvar g = 0; g < NUM_IN; g++) begin : g_pin
    ipchg_filter u_flt (
      .clk(clk), .rst_n(rst_int_n), .tick(smp_tick_i),
      .smp(smp[g]), .level(level_o[g]), .chg(chg[g])
    );
  end

  ipchg_flags #(.W(NUM_IN)) u_flags (
    .clk(clk), .rst_n(rst_int_n), .chg(chg), .rd(rd_strobe_i),
    .en(irq_en_i), .flags(delta_o), .irq(irq_o)
  );

  assign rd_data_o = {delta_o, level_o};

  logic [RW-1:0] unused_rw;
  assign unused_rw = rd_data_o;
endmodule

// File: rtl/ipchg_detect_chk.sv
module ipchg_detect_chk #(
  parameter int unsigned NUM_IN = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_tick_i,
  input logic              rd_strobe_i,
  input logic [NUM_IN-1:0] level_o,
  input logic [NUM_IN-1:0] delta_o
);
  // R2
  level_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_tick_i) |-> $stable(level_o));

  // R4
  level_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(level_o) |->
      ((delta_o & (level_o ^ $past(level_o))) == (level_o ^ $past(level_o))));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(delta_o) & ~delta_o) != '0) |-> $past(rd_strobe_i));

  // R6
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_strobe_i) && !$past(smp_tick_i)) |-> (delta_o == '0));
endmodule

bind ipchg_detect ipchg_detect_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_tick_i(smp_tick_i),
  .rd_strobe_i(rd_strobe_i), .level_o(level_o), .delta_o(delta_o)
);

// File: tb/ipchg_detect_test.sv
`timescale 1ns/1ps
module ipchg_detect_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pins;
  logic       tick, rd, en;
  logic [3:0] level_o, delta_o;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state
  bit [3:0] m_lvl, m_prev, m_flags;
  bit [3:0] pipe[$];

  always #2.5 clk = ~clk;

  ipchg_detect uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .smp_tick_i(tick),
    .rd_strobe_i(rd), .irq_en_i(en), .level_o(level_o), .delta_o(delta_o),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Drive one cycle, advance the model at the edge, compare at the falling edge.
  task automatic step(input bit [3:0] p, input bit t, input bit r, input bit e);
    bit [3:0] s, c;
    pins = p; tick = t; rd = r; en = e;
    @(posedge clk);
    s = pipe.pop_front();
    pipe.push_back(p);
    c = '0;
    if (t) begin
      for (int i = 0; i < 4; i++)
        if (s[i] == m_prev[i] && s[i] != m_lvl[i]) begin
          m_lvl[i] = s[i];
          c[i] = 1'b1;
        end
      m_prev = s;
    end
    m_flags = (r ? 4'b0 : m_flags) | c;
    @(negedge clk);
    chk("R2 level", {4'b0, level_o}, {4'b0, m_lvl});
    chk("R4 flags", {4'b0, delta_o}, {4'b0, m_flags});
    chk("R7 irq", {7'b0, irq_o}, {7'b0, e & (|m_flags)});
    chk("R8 rd_data", rd_data_o, {m_flags, m_lvl});
  endtask

  initial begin
    #1ms;
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit [3:0] p;
    bit e;
    m_lvl = 4'hF; m_prev = 4'hF; m_flags = 4'h0;
    pipe.push_back(4'hF); pipe.push_back(4'hF);
    pins = 4'hF; tick = 0; rd = 0; en = 0; rst_n = 0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 level", {4'b0, level_o}, 8'h0F);
    chk("R1 flags", {4'b0, delta_o}, 8'h00);
    chk("R1 irq", {7'b0, irq_o}, 8'h00);
    rst_n = 1;
    repeat (5) step(4'hF, 0, 0, 0);

    // R2, R4, R7, R8: falling change on pin 0, interrupt enabled
    for (int c = 0; c < 40; c++) step(4'hE, (c % 8) == 0, 0, 1);
    chk("R2 fall accepted", {4'b0, level_o}, 8'h0E);
    chk("R4 flag pin0", {4'b0, delta_o}, 8'h01);
    chk("R7 irq set", {7'b0, irq_o}, 8'h01);
    chk("R8 word", rd_data_o, 8'h1E);

    // R5: read clears
    step(4'hE, 0, 1, 1);
    chk("R5 cleared by read", {4'b0, delta_o}, 8'h00);
    chk("R7 irq low", {7'b0, irq_o}, 8'h00);

    // R3: glitch on pin 1 seen at one tick at most
    step(4'hC, 0, 0, 1);
    step(4'hC, 0, 0, 1);
    step(4'hC, 1, 0, 1);
    for (int c = 0; c < 30; c++) step(4'hE, (c % 8) == 5, 0, 1);
    chk("R3 glitch level", {4'b0, level_o}, 8'h0E);
    chk("R3 glitch flags", {4'b0, delta_o}, 8'h00);

    // R6: rising acceptance on pin 0 in the same cycle as a read
    repeat (4) step(4'hF, 0, 0, 1);
    step(4'hF, 1, 0, 1);
    repeat (2) step(4'hF, 0, 0, 1);
    step(4'hF, 1, 1, 1);
    chk("R6 kept on read", {4'b0, delta_o}, 8'h01);
    chk("R2 rise accepted", {4'b0, level_o}, 8'h0F);

    // R7: enable low masks request
    step(4'hF, 0, 0, 0);
    chk("R7 masked", {7'b0, irq_o}, 8'h00);
    step(4'hF, 0, 0, 1);
    chk("R7 unmasked", {7'b0, irq_o}, 8'h01);

    // mixed random activity against the model
    p = 4'hF; e = 1;
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < 4; i++)
        if ($urandom_range(0, 11) == 0) p[i] = ~p[i];
      if ($urandom_range(0, 60) == 0) e = ~e;
      step(p, (c % 8) == 3, $urandom_range(0, 17) == 0, e);
    end

    summary();
    $finish;
  end
endmodule